// File: doc/BRIEF.md
# Output Port Set/Clear Register with Pin Source Selection

This block holds an eight-bit general-purpose output register and drives eight output pins from it. Software never writes the register outright. It issues a set-bits command or a clear-bits command together with a data word, and only the bit positions where the word holds a one are affected. Every pin that takes its level from the register shows the inverse of the stored bit. Setting a bit therefore pulls its pin low, and clearing a bit lets the pin go high.

Two command lanes can be presented in the same clock cycle, for example from two host ports. A per-pin selection word decides whether each of pins 2 to 7 follows its register bit or a separate internal signal. Pins 0 and 1 each have two mode enables. One turns the pin into a request-to-send line, driven low only while the register bit is set and the local receiver reports that it can take data. The other turns the pin into a transmitter-done line, driven low while the transmitter reports that its last character has left. Both enables may be active on the same pin at once.

Top module: `opr_bank`

## Requirements
- R1: While reset is asserted, and after it, until a command is issued, every stored bit is 0, so every register-sourced pin is high (pins = 8'hFF with all selections and modes off).
- R2: A strobed command with code 4'hE sets to 1 each stored bit whose position holds a 1 in that lane's data word. The pins show the result after the next rising clock edge.
- R3: A strobed command with code 4'hF clears to 0 each stored bit whose position holds a 1 in that lane's data word. The pins show the result after the next rising clock edge.
- R4: Bit positions holding 0 in the data word keep their value. A lane whose strobe is low, or whose code is neither 4'hE nor 4'hF, changes no bit.
- R5: A pin sourced from the register shows the inverse of its stored bit: a stored 1 gives a low pin.
- R6: For pin i in 2..7, sel_alt bit (i-2) = 1 makes the pin follow alt_in bit (i-2) directly, with no inversion. sel_alt bit (i-2) = 0 makes it follow the inverted register bit.
- R7: With rts_en[k] = 1 and txd_en[k] = 0, pin k (k = 0 or 1) is low exactly when stored bit k is 1 and rx_ready[k] is 1.
- R8: With txd_en[k] = 1 and rts_en[k] = 0, pin k is low exactly when tx_done[k] is 1, whatever the stored bit.
- R9: With both rts_en[k] and txd_en[k] set, pin k is low when either the condition of R7 or that of R8 holds.
- R10: When one lane sets a bit and the other lane clears the same bit in the same cycle, the bit ends up 0. Bits touched by only one lane follow that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_stb | input | 1 | Lane A command strobe |
| a_code | input | 4 | Lane A command code (4'hE set, 4'hF clear) |
| a_data | input | 8 | Lane A bit mask |
| b_stb | input | 1 | Lane B command strobe |
| b_code | input | 4 | Lane B command code |
| b_data | input | 8 | Lane B bit mask |
| sel_alt | input | 6 | Source selection for pins 2..7 (1 = alternate signal) |
| alt_in | input | 6 | Alternate signals for pins 2..7 |
| rts_en | input | 2 | Request-to-send mode for pins 0 and 1 |
| rx_ready | input | 2 | Receiver can accept data, per pin 0/1 |
| txd_en | input | 2 | Transmitter-done mode for pins 0 and 1 |
| tx_done | input | 2 | Transmitter finished last character, per pin 0/1 |
| pins | output | 8 | Output pin levels |

## Verification
A set on one lane and a clear on the other can land on the same bit in the same cycle. The vector table provokes this twice: once with the two masks overlapping in only some positions, and once with the roles of the lanes swapped. It also pairs overlapping set and clear masks. Each result is judged at the pins one edge later against a value worked out by hand, in which the clear wins and the positions touched by only one lane follow that lane. The second collision is the two combined modes of a low pin, request-to-send and transmitter-done, active together. These are driven from independent inputs and checked for each way the pin can be pulled low.

// File: rtl/opr_bank.sv
module opr_bank #(
  parameter int W = 8,
  parameter logic [3:0] SET_CODE = 4'hE,
  parameter logic [3:0] CLR_CODE = 4'hF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_stb,
  input  logic [3:0]   a_code,
  input  logic [W-1:0] a_data,
  input  logic         b_stb,
  input  logic [3:0]   b_code,
  input  logic [W-1:0] b_data,
  input  logic [W-3:0] sel_alt,
  input  logic [W-3:0] alt_in,
  input  logic [1:0]   rts_en,
  input  logic [1:0]   rx_ready,
  input  logic [1:0]   txd_en,
  input  logic [1:0]   tx_done,
  output logic [W-1:0] pins
);
  localparam int HI = W - 2;

  logic [W-1:0] bits_q;
  logic [W-1:0] set_m, clr_m;

  assign set_m = ((a_stb && a_code == SET_CODE) ? a_data : '0)
               | ((b_stb && b_code == SET_CODE) ? b_data : '0);
  assign clr_m = ((a_stb && a_code == CLR_CODE) ? a_data : '0)
               | ((b_stb && b_code == CLR_CODE) ? b_data : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= (bits_q | set_m) & ~clr_m;
  end

  for (genvar k = 0; k < 2; k++) begin : g_lo
    logic pull_low;
    always_comb begin
      pull_low = txd_en[k] & tx_done[k];
      if (rts_en[k])       pull_low = pull_low | (bits_q[k] & rx_ready[k]);
      else if (!txd_en[k]) pull_low = bits_q[k];
    end
    assign pins[k] = ~pull_low;
  end

  for (genvar i = 0; i < HI; i++) begin : g_hi
    assign pins[i+2] = sel_alt[i] ? alt_in[i] : ~bits_q[i+2];
  end
endmodule

module opr_bank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_stb,
  input logic [3:0]   a_code,
  input logic [W-1:0] a_data,
  input logic         b_stb,
  input logic [3:0]   b_code,
  input logic [W-1:0] b_data,
  input logic [W-3:0] sel_alt,
  input logic [W-3:0] alt_in,
  input logic [1:0]   rts_en,
  input logic [1:0]   rx_ready,
  input logic [1:0]   txd_en,
  input logic [1:0]   tx_done,
  input logic [W-1:0] pins,
  input logic [W-1:0] bits_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> bits_q == '0);

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_stb && a_code == 4'hE && !b_stb) |=> ((bits_q & $past(a_data)) == $past(a_data)));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_stb && b_code == 4'hF) |=> ((bits_q & $past(b_data)) == '0));

  // R4
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_stb && !b_stb) |=> $stable(bits_q));

  // R4
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_stb && !b_stb) |=> (!($stable(sel_alt) && $stable(alt_in) && $stable(rts_en) &&
      $stable(rx_ready) && $stable(txd_en) && $stable(tx_done)) || $stable(pins)));

  // R8
  txdone_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_en[0] && tx_done[0]) |-> !pins[0]);
endmodule

bind opr_bank opr_bank_chk #(.W(W)) chk_i (.*);

// File: tb/opr_bank_tb_top.sv
module opr_bank_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic a_stb = 0, b_stb = 0;
  logic [3:0] a_code = 0, b_code = 0;
  logic [7:0] a_data = 0, b_data = 0;
  logic [5:0] sel_alt = 0, alt_in = 0;
  logic [1:0] rts_en = 0, rx_ready = 0, txd_en = 0, tx_done = 0;
  logic [7:0] pins;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  opr_bank dut_i (.*);

  // fields: tag, a_stb, a_code, a_data, b_stb, b_code, b_data, expected pins
  localparam int NV = 10;
  localparam logic [41:0] VEC [NV] = '{
    {8'd2,  1'b1, 4'hE, 8'hA5, 1'b0, 4'h0, 8'h00, 8'h5A}, // R2
    {8'd3,  1'b1, 4'hF, 8'h0F, 1'b0, 4'h0, 8'h00, 8'h5F}, // R3
    {8'd4,  1'b1, 4'hE, 8'h00, 1'b0, 4'h0, 8'h00, 8'h5F}, // R4
    {8'd4,  1'b1, 4'h3, 8'hFF, 1'b0, 4'h0, 8'h00, 8'h5F}, // R4
    {8'd4,  1'b0, 4'hE, 8'hFF, 1'b0, 4'hF, 8'hFF, 8'h5F}, // R4
    {8'd2,  1'b0, 4'h0, 8'h00, 1'b1, 4'hE, 8'h0C, 8'h53}, // R2
    {8'd10, 1'b1, 4'hE, 8'h03, 1'b1, 4'hF, 8'h81, 8'hD1}, // R10
    {8'd10, 1'b1, 4'hF, 8'h0F, 1'b1, 4'hE, 8'h0F, 8'hDF}, // R10
    {8'd5,  1'b1, 4'hE, 8'hFF, 1'b0, 4'h0, 8'h00, 8'h00}, // R5
    {8'd3,  1'b0, 4'h0, 8'h00, 1'b1, 4'hF, 8'hFF, 8'hFF}  // R3
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s pins=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] c, input logic [7:0] d);
    a_stb = 1; a_code = c; a_data = d;
    @(negedge clk);
    a_stb = 0;
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pins, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    check("R1", pins, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      {a_stb, a_code, a_data, b_stb, b_code, b_data} = VEC[i][33:8];
      @(negedge clk);
      a_stb = 0; b_stb = 0;
      check($sformatf("R%0d vec%0d", VEC[i][41:34], i), pins, VEC[i][7:0]);
    end

    // R6: pin 2 from alternate, others from register (stored 8'h04)
    cmd(4'hE, 8'h04);
    check("R5", pins, 8'hFB);
    sel_alt = 6'b000001; alt_in = 6'b000001; #1;
    check("R6", pins, 8'hFF);
    alt_in = 6'b000000; #1;
    check("R6", pins, 8'hFB);
    alt_in = 6'b000010; #1;
    check("R6", pins, 8'hFB);
    sel_alt = 0; alt_in = 0;
    cmd(4'hF, 8'hFF);

    // R7: request-to-send on pin 0
    rts_en = 2'b01; rx_ready = 2'b01; #1;
    check("R7", pins, 8'hFF);
    cmd(4'hE, 8'h01);
    check("R7", pins, 8'hFE);
    rx_ready = 0; #1;
    check("R7", pins, 8'hFF);
    rts_en = 0; #1;
    check("R5", pins, 8'hFE);
    cmd(4'hF, 8'h01);

    // R8: transmitter-done on pin 1
    txd_en = 2'b10; tx_done = 2'b10; #1;
    check("R8", pins, 8'hFD);
    tx_done = 0; #1;
    check("R8", pins, 8'hFF);
    cmd(4'hE, 8'h02);
    check("R8", pins, 8'hFF);
    txd_en = 0; #1;
    check("R5", pins, 8'hFD);
    cmd(4'hF, 8'h02);

    // R9: both modes on pin 0, stored bit set
    cmd(4'hE, 8'h01);
    rts_en = 2'b01; txd_en = 2'b01; rx_ready = 0; tx_done = 2'b01; #1;
    check("R9", pins, 8'hFE);
    tx_done = 0; #1;
    check("R9", pins, 8'hFF);
    rx_ready = 2'b01; #1;
    check("R9", pins, 8'hFE);
    rts_en = 0; txd_en = 0; rx_ready = 0;

    // R1: reset again after activity
    cmd(4'hE, 8'hF0);
    rst_n = 0;
    @(negedge clk);
    check("R1", pins, 8'hFF);
    rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule